// File: doc/BRIEF.md
# Descriptor ROM Entry List Walker

This block steps through the chain of variable-length records that sits after the fixed 22-byte header of a device descriptor image. The image is held in a byte-wide buffer that the block reads through a synchronous port. Each record starts with a two-byte header. The first byte is the record length, and that length counts the header. The second byte holds the record index, a disabled flag and a type bit. The block checks each record against the image bounds and decodes port records into link and partner information. Generic records are reported with the location and length of their payload, so that a consumer can copy name strings itself. Index 1 carries the vendor name and index 2 carries the device name.

A controller sets the image size and the highest valid port number, then pulses `start`. The block reports each accepted record with a one-cycle pulse on `ent_valid`. It ends in one of three held states: `done` when the list ended cleanly, `err_overrun` when a record broke the bounds, or `err_port_len` when an enabled port record had the wrong size.

Top module: `rom_entry_walker`

## Requirements
- R1: A `start` pulse is accepted only when `busy` is low. It latches `image_size` and `max_port`, places the walk position at byte offset 22 and raises `busy` on the next cycle. A `start` pulse while `busy` is high has no effect.
- R2: When the position is at or beyond the latched size, the walk ends with `done` high. A size of 22 gives `done` with no record reported.
- R3: Record header layout: byte 0 is the total record length, with the 2 header bytes included. In byte 1, bits [5:0] are the index, bit 6 is the disabled flag and bit 7 is the type (1 means port, 0 means generic).
- R4: The walk stops with `err_overrun` and reports nothing more in any of three cases: the length byte is 0, position+1 equals the size, or position+length is greater than the size.
- R5: A port record whose index is greater than the latched `max_port` gives no pulse and no error, whatever its length, and the walk continues after it.
- R6: A disabled port record whose index is in range is reported with `ent_disabled`=1. Its link, partner flag and partner number read as 0, its length is not checked and its later bytes are not read.
- R7: An enabled port record whose index is in range must have length 8. Any other length ends the walk with `err_port_len` and no pulse for that record.
- R8: For an enabled port record, byte 2 bit 4 gives `ent_link`, byte 2 bit 7 gives `ent_has_dual`, and byte 3 bits [5:0] give `ent_dual_port`.
- R9: A generic record is reported with `ent_is_port`=0, its index, `ent_payload_len` equal to the length minus 2, and `ent_payload_addr` equal to the record position plus 2. Port records report 0 in both payload fields.
- R10: After each record the position advances by exactly that record's length. Records are reported in buffer order, at most one pulse per cycle. The block issues at most one read per cycle, expects the data one cycle after the read, and never reads at or beyond the latched size.
- R11: `done`, `err_overrun` and `err_port_len` stay high until the next accepted `start`. At most one of these three flags and `busy` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a walk |
| image_size | input | SZ_W | Total image size in bytes, header included |
| max_port | input | 6 | Highest port index that is accepted |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | SZ_W | Buffer byte address |
| rd_data | input | 8 | Buffer data, valid one cycle after `rd_en` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | List ended cleanly |
| err_overrun | output | 1 | A record broke the image bounds |
| err_port_len | output | 1 | An enabled port record was not 8 bytes long |
| ent_valid | output | 1 | One-cycle pulse: the entry fields are valid |
| ent_is_port | output | 1 | Record type: 1 for port, 0 for generic |
| ent_index | output | 6 | Record index |
| ent_disabled | output | 1 | Port is marked disabled |
| ent_link | output | 1 | Port link number |
| ent_has_dual | output | 1 | Port has a dual-link partner |
| ent_dual_port | output | 6 | Partner port number |
| ent_payload_len | output | 8 | Generic payload length in bytes |
| ent_payload_addr | output | SZ_W | Address of the first generic payload byte |

## Verification
The overrun case where exactly one byte is left before the image end is the hardest to reach, because it needs a chain of earlier records that all pass the checks and land one byte short of the size. The stimulus builds images with a short valid record and a size set one byte past its end. A second hard case is a `start` pulse that arrives in the middle of a walk. The stimulus pulses `start` with a different size two cycles into a long walk, and the scoreboard then expects the full original list. A third case is a skipped record with an out-of-range index, a short length and a port type: the stimulus places it just before the end of the image, so that a wrong length check would show up as an error flag.

// File: rtl/rom_walk_pkg.sv
package rom_walk_pkg;
  localparam int IDX_W        = 6;
  localparam int PORT_REC_LEN = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_LEN, S_HDR, S_B2, S_B3,
    S_EMIT, S_DONE, S_OVR, S_BADLEN
  } walk_state_e;
endpackage

// File: rtl/rom_walk_bounds.sv
module rom_walk_bounds #(
  parameter int SZ_W = 16
) (
  input  logic [SZ_W-1:0] pos,
  input  logic [SZ_W-1:0] size,
  input  logic [7:0]      len,
  output logic            at_end,
  output logic            last_byte,
  output logic            len_bad
);
  localparam int EW = SZ_W + 1;
  logic [EW-1:0] pos_plus_len;
  logic [EW-1:0] pos_plus_one;

  always_comb begin
    pos_plus_len = {1'b0, pos} + EW'(len);
    pos_plus_one = {1'b0, pos} + EW'(1);
    at_end       = (pos >= size);
    last_byte    = (pos_plus_one == {1'b0, size});
    len_bad      = (len == 8'd0) || (pos_plus_len > {1'b0, size});
  end
endmodule

// File: rtl/rom_walk_byte_dec.sv
module rom_walk_byte_dec
  import rom_walk_pkg::*;
(
  input  logic [7:0]       byte_in,
  output logic [IDX_W-1:0] idx,
  output logic             dis_bit,
  output logic             type_bit,
  output logic             link_bit,
  output logic             dual_bit,
  output logic [IDX_W-1:0] partner
);
  always_comb begin
    idx      = byte_in[5:0];
    dis_bit  = byte_in[6];
    type_bit = byte_in[7];
    link_bit = byte_in[4];
    dual_bit = byte_in[7];
    partner  = byte_in[5:0];
  end
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
  import rom_walk_pkg::*;
#(
  parameter int SZ_W    = 16,
  parameter int HDR_LEN = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SZ_W-1:0] image_size,
  input  logic [5:0]      max_port,
  output logic            rd_en,
  output logic [SZ_W-1:0] rd_addr,
  input  logic [7:0]      rd_data,
  output logic            busy,
  output logic            done,
  output logic            err_overrun,
  output logic            err_port_len,
  output logic            ent_valid,
  output logic            ent_is_port,
  output logic [5:0]      ent_index,
  output logic            ent_disabled,
  output logic            ent_link,
  output logic            ent_has_dual,
  output logic [5:0]      ent_dual_port,
  output logic [7:0]      ent_payload_len,
  output logic [SZ_W-1:0] ent_payload_addr
);
  localparam logic [SZ_W-1:0] START_POS = SZ_W'(HDR_LEN);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  walk_state_e      state_q, state_d;
  logic [SZ_W-1:0]  pos_q, pos_d, size_q, size_d, paddr_q, paddr_d;
  logic [IDX_W-1:0] maxp_q, maxp_d, idx_q, idx_d, dport_q, dport_d;
  logic [7:0]       len_q, len_d, plen_q, plen_d;
  logic             isport_q, isport_d, dis_q, dis_d;
  logic             link_q, link_d, hasd_q, hasd_d;

  logic             at_end, last_byte, len_bad;
  logic [IDX_W-1:0] dec_idx, dec_partner;
  logic             dec_dis, dec_type, dec_link, dec_dual;
  logic             can_start;

  rom_walk_bounds #(.SZ_W(SZ_W)) u_bounds (
    .pos(pos_q), .size(size_q), .len(rd_data),
    .at_end(at_end), .last_byte(last_byte), .len_bad(len_bad)
  );

  rom_walk_byte_dec u_dec (
    .byte_in(rd_data), .idx(dec_idx), .dis_bit(dec_dis), .type_bit(dec_type),
    .link_bit(dec_link), .dual_bit(dec_dual), .partner(dec_partner)
  );

  assign can_start = (state_q == S_IDLE) || (state_q == S_DONE) ||
                     (state_q == S_OVR)  || (state_q == S_BADLEN);

  // next-state process
  always_comb begin
    state_d  = state_q;  pos_d  = pos_q;   size_d = size_q;  maxp_d = maxp_q;
    len_d    = len_q;    idx_d  = idx_q;   dport_d = dport_q;
    plen_d   = plen_q;   paddr_d = paddr_q;
    isport_d = isport_q; dis_d  = dis_q;   link_d = link_q;  hasd_d = hasd_q;
    rd_en    = 1'b0;
    rd_addr  = pos_q;
    unique case (state_q)
      S_CHECK: begin
        if (at_end)         state_d = S_DONE;
        else if (last_byte) state_d = S_OVR;
        else begin
          rd_en   = 1'b1;
          state_d = S_LEN;
        end
      end
      S_LEN: begin
        len_d = rd_data;
        if (len_bad) state_d = S_OVR;
        else begin
          rd_en   = 1'b1;
          rd_addr = pos_q + SZ_W'(1);
          state_d = S_HDR;
        end
      end
      S_HDR: begin
        isport_d = dec_type;
        idx_d    = dec_idx;
        dis_d    = dec_type & dec_dis;
        link_d   = 1'b0;
        hasd_d   = 1'b0;
        dport_d  = '0;
        plen_d   = dec_type ? 8'd0 : (len_q - 8'd2);
        paddr_d  = dec_type ? '0 : (pos_q + SZ_W'(2));
        if (!dec_type)               state_d = S_EMIT;
        else if (dec_idx > maxp_q) begin
          pos_d   = pos_q + SZ_W'(len_q);
          state_d = S_CHECK;
        end
        else if (dec_dis)            state_d = S_EMIT;
        else if (len_q != 8'(PORT_REC_LEN)) state_d = S_BADLEN;
        else begin
          rd_en   = 1'b1;
          rd_addr = pos_q + SZ_W'(2);
          state_d = S_B2;
        end
      end
      S_B2: begin
        link_d  = dec_link;
        hasd_d  = dec_dual;
        rd_en   = 1'b1;
        rd_addr = pos_q + SZ_W'(3);
        state_d = S_B3;
      end
      S_B3: begin
        dport_d = dec_partner;
        state_d = S_EMIT;
      end
      S_EMIT: begin
        pos_d   = pos_q + SZ_W'(len_q);
        state_d = S_CHECK;
      end
      default: begin
        if (start) begin
          pos_d   = START_POS;
          size_d  = image_size;
          maxp_d  = max_port;
          state_d = S_CHECK;
        end
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; pos_q <= '0; size_q <= '0; maxp_q <= '0;
      len_q <= '0; idx_q <= '0; dport_q <= '0; plen_q <= '0; paddr_q <= '0;
      isport_q <= 1'b0; dis_q <= 1'b0; link_q <= 1'b0; hasd_q <= 1'b0;
    end else begin
      state_q <= state_d; pos_q <= pos_d; size_q <= size_d; maxp_q <= maxp_d;
      len_q <= len_d; idx_q <= idx_d; dport_q <= dport_d; plen_q <= plen_d;
      paddr_q <= paddr_d; isport_q <= isport_d; dis_q <= dis_d;
      link_q <= link_d; hasd_q <= hasd_d;
    end
  end

  assign busy             = !can_start;
  assign done             = (state_q == S_DONE);
  assign err_overrun      = (state_q == S_OVR);
  assign err_port_len     = (state_q == S_BADLEN);
  assign ent_valid        = (state_q == S_EMIT);
  assign ent_is_port      = isport_q;
  assign ent_index        = idx_q;
  assign ent_disabled     = dis_q;
  assign ent_link         = link_q;
  assign ent_has_dual     = hasd_q;
  assign ent_dual_port    = dport_q;
  assign ent_payload_len  = plen_q;
  assign ent_payload_addr = paddr_q;

  // assertions
  assert_read_in_bounds_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en |-> (rd_addr < size_q));
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    ent_valid |=> !ent_valid);
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({busy, done, err_overrun, err_port_len}));
  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (start && !busy) |=> busy);
  assert_disabled_zero_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ent_valid && ent_disabled) |-> (!ent_link && !ent_has_dual && ent_dual_port == '0));
  assert_port_in_range_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ent_valid && ent_is_port) |-> (ent_index <= maxp_q));
  assert_done_from_walk_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done) |-> $past(busy));
  assert_no_read_after_err_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (err_overrun || err_port_len) |-> !rd_en);
endmodule

// File: tb/sim_rom_entry_walker.sv
`timescale 1ns/1ps
module sim_rom_entry_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] image_size;
  logic [5:0]  max_port;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        busy, done, err_overrun, err_port_len, ent_valid;
  logic        ent_is_port, ent_disabled, ent_link, ent_has_dual;
  logic [5:0]  ent_index, ent_dual_port;
  logic [7:0]  ent_payload_len;
  logic [15:0] ent_payload_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  mem [256];
  logic [39:0] expq [$];

  always #2 clk = ~clk;

  rom_entry_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .image_size(image_size),
    .max_port(max_port), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err_overrun(err_overrun), .err_port_len(err_port_len),
    .ent_valid(ent_valid), .ent_is_port(ent_is_port), .ent_index(ent_index),
    .ent_disabled(ent_disabled), .ent_link(ent_link), .ent_has_dual(ent_has_dual),
    .ent_dual_port(ent_dual_port), .ent_payload_len(ent_payload_len),
    .ent_payload_addr(ent_payload_addr)
  );

  // buffer model: data one cycle after the read
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each reported entry against the scoreboard
  always @(negedge clk) begin
    if (rst_n && ent_valid) begin
      logic [39:0] got;
      got = {ent_is_port, ent_index, ent_disabled, ent_link, ent_has_dual,
             ent_dual_port, ent_payload_len, ent_payload_addr};
      if (expq.size() == 0)
        chk(1'b0, "R10", "unexpected entry", got, 0);
      else begin
        logic [39:0] e;
        e = expq.pop_front();
        chk(got == e, got[39] ? "R8/R6/R3" : "R9/R3", "entry fields", got, e);
      end
    end
  end

  // expected-result model built from the requirements
  task automatic model(input int size, input int maxp, output int res);
    int pos;
    pos = 22; res = 0;
    while (pos < size) begin
      int len;
      logic [7:0] b1, b2, b3;
      len = mem[pos];
      if (pos + 1 == size || len == 0 || pos + len > size) begin res = 1; return; end
      b1 = mem[pos+1];
      if (!b1[7]) begin
        logic [7:0]  pl;
        logic [15:0] pa;
        pl = 8'(len - 2);
        pa = 16'(pos + 2);
        expq.push_back({1'b0, b1[5:0], 1'b0, 1'b0, 1'b0, 6'd0, pl, pa});
      end else if (int'(b1[5:0]) > maxp) begin
        // R5: out-of-range port, skipped
      end else if (b1[6]) begin
        expq.push_back({1'b1, b1[5:0], 1'b1, 1'b0, 1'b0, 6'd0, 8'd0, 16'd0});
      end else if (len != 8) begin
        res = 2; return;
      end else begin
        b2 = mem[pos+2]; b3 = mem[pos+3];
        expq.push_back({1'b1, b1[5:0], 1'b0, b2[4], b2[7], b3[5:0], 8'd0, 16'd0});
      end
      pos += len;
    end
  endtask

  task automatic setb(input int a, input logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic run(input int size, input int maxp, input bit restart);
    int res;
    int waitc;
    model(size, maxp, res);
    @(negedge clk);
    image_size = 16'(size); max_port = 6'(maxp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (restart) begin
      // R1: start during a walk must be ignored
      @(negedge clk);
      image_size = 16'd22; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitc = 0;
    while (!(done || err_overrun || err_port_len) && waitc < 5000) begin
      @(negedge clk); waitc++;
    end
    case (res)
      0: chk(done && !err_overrun && !err_port_len, "R2", "done outcome",
             {done, err_overrun, err_port_len}, 3'b100);
      1: chk(err_overrun && !done && !err_port_len, "R4", "overrun outcome",
             {done, err_overrun, err_port_len}, 3'b010);
      default: chk(err_port_len && !done && !err_overrun, "R7", "port length outcome",
             {done, err_overrun, err_port_len}, 3'b001);
    endcase
    chk(expq.size() == 0, "R10", "entries left unreported", expq.size(), 0);
    expq.delete();
    repeat (3) @(negedge clk);
    chk(!busy && ((res == 0) ? done : (res == 1) ? err_overrun : err_port_len),
        "R11", "outcome flag held", {busy, done, err_overrun, err_port_len}, res);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    rst_n = 1'b0; start = 1'b0; image_size = '0; max_port = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err_overrun && !err_port_len && !ent_valid, "R11",
        "reset state", {busy, done, err_overrun, err_port_len, ent_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // mixed list, R3 R5 R6 R8 R9, with a start during the walk (R1)
    setb(22, 8'h05); setb(23, 8'h01); setb(24, 8'h61); setb(25, 8'h62); setb(26, 8'h63);
    setb(27, 8'h08); setb(28, 8'h81); setb(29, 8'h90); setb(30, 8'h02);
    setb(35, 8'h08); setb(36, 8'hC2);
    setb(43, 8'h08); setb(44, 8'h89);
    setb(51, 8'h02); setb(52, 8'h02);
    setb(53, 8'h08); setb(54, 8'h85); setb(55, 8'h00); setb(56, 8'h3F);
    run(61, 5, 1'b1);

    // R2: empty list
    run(22, 5, 1'b0);

    // R4: zero length after one good record
    setb(22, 8'h04); setb(23, 8'h01); setb(26, 8'h00);
    run(40, 5, 1'b0);

    // R4: exactly one byte left before the end
    setb(22, 8'h04); setb(23, 8'h00);
    run(27, 5, 1'b0);

    // R4: record runs past the end
    setb(22, 8'h0A); setb(23, 8'h01);
    run(30, 5, 1'b0);

    // R7: enabled port with length 6
    setb(22, 8'h03); setb(23, 8'h02); setb(25, 8'h06); setb(26, 8'h83);
    run(40, 5, 1'b0);

    // R6 disabled short record accepted, R5 short out-of-range port skipped
    setb(22, 8'h06); setb(23, 8'hC3); setb(28, 8'h03); setb(29, 8'h94);
    run(31, 5, 1'b0);

    // R8 boundary: max_port 0, port index 0
    setb(22, 8'h08); setb(23, 8'h80); setb(24, 8'h10); setb(25, 8'h01);
    run(30, 0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule